// File: doc/BRIEF.md
# Two-Phase Comparator Level Sanitiser

This block takes a comparator level that may glitch or fail to hold, and produces a clean output that moves only when a control signal asks it to. The control input and the clean output form a four-phase handshake. Raising the control arms the block to look for a high raw level. After the high level has been qualified, the clean output goes high. Dropping the control arms it to look for a low raw level. After that low level has been qualified, the clean output goes low. How long each phase of the handshake takes therefore depends on the raw input.

The raw level first passes through a flop synchronizer. It then has to be seen on a number of consecutive synchronized samples before it is accepted. A pulse shorter than that window is dropped, and this is not treated as an error. A mode pin selects a single-phase variant. In that mode only the high capture waits on the raw level, and the clean output clears on the clock edge after the control is released. Both the control and the mode are plain level pins. The block carries no data stream, so it has no valid/ready interface.

Top module: `level_sanitizer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `clean_out` is 0.
- R2: In two-phase mode (`one_phase`=0), with `arm_req`=1 and `clean_out`=0, suppose `cmp_raw` is held at 1 from just before clock edge k. Then `clean_out` becomes 1 right after edge k+SYNC_STAGES+QUAL_COUNT-1 and not earlier. With the defaults (2 and 2) that is edge k+3.
- R3: In two-phase mode, with `arm_req`=0 and `clean_out`=1, `cmp_raw` held at 0 lowers `clean_out` with the same latency as R2.
- R4: A synchronized level that lasts fewer than QUAL_COUNT consecutive samples never changes `clean_out`.
- R5: While `clean_out` equals `arm_req`, changes on `cmp_raw` have no effect: `clean_out` holds on the next cycle.
- R6: In single-phase mode (`one_phase`=1), when `arm_req` is 0 and `clean_out` is 1, `clean_out` is 0 after the next clock edge, whatever the value of `cmp_raw`.
- R7: In single-phase mode, the rise of `clean_out` after `arm_req` rises follows the same qualification and latency as R2.
- R8: `clean_out` rises only while `arm_req` is 1, and falls only while `arm_req` is 0.
- R9: A sample that does not match restarts the qualification count. An alternating pattern 1,0,1,0 on `cmp_raw` therefore never qualifies when QUAL_COUNT is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_req | input | 1 | Handshake control: 1 requests a high capture, 0 requests a low capture (or a release in single-phase mode) |
| one_phase | input | 1 | Mode: 0 selects two-phase, 1 selects single-phase |
| cmp_raw | input | 1 | Raw, asynchronous comparator level |
| clean_out | output | 1 | Sanitised level; the acknowledge side of the handshake |

## Verification
The bench first measures the exact edge on which `clean_out` moves in both directions. An off-by-one in the synchronizer or the counter would show up here as an early or late acknowledge. It then sends single-cycle spikes and alternating levels. A counter that accumulates samples instead of requiring them to be consecutive would let these pass. It holds the output at the requested phase while the raw level moves, where a block that follows the raw level would drop the acknowledge. It also releases the control in single-phase mode while the raw level is still high, where a design that waited for a low level would keep the output set. A long seeded random run then compares every cycle against a model built from the requirements, in both modes.

// File: rtl/lsan_pkg.sv
package lsan_pkg;
  // Next-state decision for the clean output
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2
  } lsan_act_e;
endpackage

// File: rtl/lsan_sync.sv
module lsan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lsan_qualifier.sv
module lsan_qualifier #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic match,
  output logic accept
);
  localparam int CNT_W = (QUAL > 1) ? $clog2(QUAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL - 1);

  logic [CNT_W-1:0] run_cnt;

  // the current sample completes a run of QUAL matching samples
  assign accept = armed && match && (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run_cnt <= '0;
    else if (!armed || !match || accept) run_cnt <= '0;
    else                             run_cnt <= run_cnt + 1'b1;
  end
endmodule

// File: rtl/lsan_phase.sv
module lsan_phase
  import lsan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic one_phase,
  input  logic accept,
  output logic armed,
  output logic level
);
  lsan_act_e act;

  // armed only when the output differs from the requested phase and that
  // phase is one the mode actually waits for
  assign armed = (level != arm_req) && (arm_req || !one_phase);

  always_comb begin
    act = ACT_HOLD;
    if (one_phase && !arm_req && level) act = ACT_CLEAR;
    else if (accept)                    act = arm_req ? ACT_SET : ACT_CLEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else begin
      unique case (act)
        ACT_SET:   level <= 1'b1;
        ACT_CLEAR: level <= 1'b0;
        default:   level <= level;
      endcase
    end
  end
endmodule

// File: rtl/level_sanitizer.sv
module level_sanitizer #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_COUNT  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic one_phase,
  input  logic cmp_raw,
  output logic clean_out
);
  logic raw_sync;
  logic armed;
  logic accept;
  logic level_match;

  lsan_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cmp_raw), .q_sync(raw_sync)
  );

  assign level_match = (raw_sync == arm_req);

  lsan_qualifier #(.QUAL(QUAL_COUNT)) u_qual (
    .clk(clk), .rst_n(rst_n), .armed(armed), .match(level_match), .accept(accept)
  );

  lsan_phase u_phase (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .one_phase(one_phase),
    .accept(accept), .armed(armed), .level(clean_out)
  );
endmodule

// File: rtl/lsan_checker.sv
module lsan_checker #(
  parameter int QUAL = 2
) (
  input logic clk,
  input logic rst_n,
  input logic arm_req,
  input logic one_phase,
  input logic raw_sync,
  input logic clean_out
);
  localparam int RW = $clog2(QUAL + 1) + 1;
  logic [RW-1:0] hi_run, lo_run;

  // saturating run lengths of the synchronized level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      if (!raw_sync)               hi_run <= '0;
      else if (hi_run < RW'(QUAL)) hi_run <= hi_run + 1'b1;
      if (raw_sync)                lo_run <= '0;
      else if (lo_run < RW'(QUAL)) lo_run <= lo_run + 1'b1;
    end
  end

  always_comb begin
    if (!rst_n) assert_reset_low_R1: assert (clean_out == 1'b0);
  end

  assert_rise_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clean_out) |-> hi_run >= RW'(QUAL));

  assert_fall_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clean_out) && !$past(one_phase)) |-> lo_run >= RW'(QUAL));

  assert_hold_when_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_out == arm_req) |=> $stable(clean_out));

  assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (one_phase && !arm_req && clean_out) |=> !clean_out);

  assert_rise_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clean_out) |-> $past(arm_req));

  assert_fall_needs_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clean_out) |-> !$past(arm_req));
endmodule

bind level_sanitizer lsan_checker #(.QUAL(QUAL_COUNT)) u_lsan_chk (
  .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .one_phase(one_phase),
  .raw_sync(raw_sync), .clean_out(clean_out)
);

// File: tb/tb_level_sanitizer.sv
`timescale 1ns/1ps
module tb_level_sanitizer;
  localparam int SYNC = 2;
  localparam int QUAL = 2;
  localparam int LAT  = SYNC + QUAL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_req = 1'b0, one_phase = 1'b0, cmp_raw = 1'b0;
  logic clean_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  level_sanitizer #(.SYNC_STAGES(SYNC), .QUAL_COUNT(QUAL)) dut (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .one_phase(one_phase),
    .cmp_raw(cmp_raw), .clean_out(clean_out)
  );

  // reference model from the requirements
  logic [SYNC-1:0] m_sync;
  int m_run;
  logic m_out;

  function automatic bit qualifies(input int run);
    return (run + 1) >= QUAL;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= '0; m_run <= 0; m_out <= 1'b0;
    end else begin
      m_sync <= {m_sync[SYNC-2:0], cmp_raw};
      if (one_phase && !arm_req) begin
        m_out <= 1'b0; m_run <= 0;
      end else if (m_out != arm_req && m_sync[SYNC-1] == arm_req) begin
        if (qualifies(m_run)) begin m_out <= arm_req; m_run <= 0; end
        else m_run <= m_run + 1;
      end else m_run <= 0;
    end
  end

  task automatic check(input string req, input logic exp);
    checks++;
    if (clean_out !== exp) begin
      errors++;
      $display("FAIL %s: clean_out=%b expected=%b at %0t", req, clean_out, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: run=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    cyc(3);
    check("R1", 1'b0);
    rst_n = 1'b1;
    cyc(1);
    check("R1", 1'b0);

    // R2: latency in two-phase mode
    arm_req = 1'b1; cmp_raw = 1'b1;
    cyc(LAT - 1); check("R2", 1'b0);
    cyc(1);       check("R2", 1'b1);

    // R5: raw moves while output equals request
    for (int i = 0; i < 10; i++) begin
      cmp_raw = ~cmp_raw; cyc(1); check("R5", 1'b1);
    end

    // R3: low capture
    cmp_raw = 1'b0; arm_req = 1'b0;
    cyc(LAT - 1); check("R3", 1'b1);
    cyc(1);       check("R3", 1'b0);

    // R4: single-cycle spike while armed high
    arm_req = 1'b1;
    cmp_raw = 1'b1; cyc(1); cmp_raw = 1'b0;
    cyc(8); check("R4", 1'b0);

    // R9: alternating pattern never qualifies
    for (int i = 0; i < 12; i++) begin
      cmp_raw = ~cmp_raw; cyc(1);
    end
    cmp_raw = 1'b0; cyc(LAT); check("R9", 1'b0);

    // R7 / R6: single-phase mode
    one_phase = 1'b1; cmp_raw = 1'b1;
    cyc(LAT - 1); check("R7", 1'b0);
    cyc(1);       check("R7", 1'b1);
    arm_req = 1'b0;
    cyc(1); check("R6", 1'b0);
    cyc(5); check("R6", 1'b0);

    // R8: seeded random run against the model, both modes
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 3) == 0) cmp_raw = ~cmp_raw;
      if ($urandom_range(0, 11) == 0) arm_req = ~arm_req;
      if ($urandom_range(0, 199) == 0) one_phase = ~one_phase;
      cyc(1);
      check("R8", m_out);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule